// File: doc/BRIEF.md
# Hybrid Lookahead Adder (Four-Bit Groups, Rippled)

This block is a purely combinational binary adder. It splits its operands into four-bit slices. Inside each slice the carries are found in parallel from per-bit generate and propagate terms using flat AND-OR equations. The slices are then chained, so a slice's outgoing carry becomes the incoming carry of the slice above it. The default width is sixteen bits, built from four slices. The slice count is a parameter.

Each sum bit is formed by XOR of the two operand bits and the carry that the lookahead logic delivers to that position. The sum logic makes no carries of its own. The block is dropped into a datapath wherever a single-cycle add of two operands plus an incoming carry is needed. It returns the full sum and the carry leaving the top bit.

Top module: `cla_hybrid_adder`

## Requirements
- R1: A bit position where both operand bits are 1 always delivers a carry of 1 into the next position (or to `carry_out` for the top bit), whatever the lower bits hold.
- R2: A bit position where exactly one operand bit is 1 passes its incoming carry upward unchanged. A position where both operand bits are 0 delivers a carry of 0 upward.
- R3: Sum bit i equals op_a[i] XOR op_b[i] XOR the carry into position i. Position 0 receives `carry_in`.
- R4: The carry entering every position, including the slice boundaries at bits 4, 8 and 12, equals the carry that a bit-serial addition of the same operands and `carry_in` produces there.
- R5: A carry produced in one slice crosses into the next slice. For example, 0x000F + 0x0001 with carry_in 0 gives 0x0010 and carry_out 0.
- R6: All-ones plus one (0xFFFF + 0x0001, carry_in 0) gives a sum of 0x0000 and carry_out 1.
- R7: Zero plus zero with carry_in 1 gives a sum of 0x0001 and carry_out 0. Zero plus zero with carry_in 0 gives all-zero outputs.
- R8: For any inputs, {carry_out, sum_out} equals op_a + op_b + carry_in as a 17-bit unsigned value.
- R9: A carry-in can travel through every slice. 0xFFFF + 0x0000 with carry_in 1 gives a sum of 0x0000 and carry_out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (4 × NUM_GRP bits) |
| op_b | input | 16 | Second operand (4 × NUM_GRP bits) |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry leaving the top bit |

## Verification
The hardest case to reach is a long propagate run: a carry that starts at the bottom and has to pass through every slice boundary. Random operands almost never produce one, because each position must hold exactly one set bit. The stimulus therefore adds directed patterns at every bit position: a single generating pair, a propagate run of increasing length fed by carry_in, and a zero pair that stops the run. On top of these it checks the all-ones and all-zero extremes. Every vector, directed or random, is compared against a sum computed in the bench and a carry vector computed bit-serially, so the carry at each slice boundary is checked directly.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Bits per lookahead slice; the flat carry equations below are written
    // for exactly four bits so that no AND or OR term exceeds five inputs.
    localparam int unsigned GRP_W = 4;

    typedef struct packed {
        logic gen;   // both operand bits set
        logic prop;  // at least one operand bit set
    } pg_t;

    function automatic pg_t pg_of(input logic a_bit, input logic b_bit);
        pg_t r;
        r.gen  = a_bit & b_bit;
        r.prop = a_bit | b_bit;
        return r;
    endfunction

endpackage

// File: rtl/cla_pg_unit.sv
module cla_pg_unit
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] a_in,
    input  logic [GRP_W-1:0] b_in,
    output pg_t  [GRP_W-1:0] pg_out
);

    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
        assign pg_out[i] = pg_of(a_in[i], b_in[i]);
    end

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
    import cla_pkg::*;
(
    input  pg_t  [GRP_W-1:0] pg_in,
    input  logic             c_in,
    output logic [GRP_W:0]   carries
);

    logic g0, g1, g2, g3;
    logic p0, p1, p2, p3;

    assign g0 = pg_in[0].gen;
    assign g1 = pg_in[1].gen;
    assign g2 = pg_in[2].gen;
    assign g3 = pg_in[3].gen;
    assign p0 = pg_in[0].prop;
    assign p1 = pg_in[1].prop;
    assign p2 = pg_in[2].prop;
    assign p3 = pg_in[3].prop;

    // Flat two-level sum-of-products; widest term has five inputs.
    assign carries[0] = c_in;
    assign carries[1] = g0
                      | (p0 & c_in);
    assign carries[2] = g1
                      | (p1 & g0)
                      | (p1 & p0 & c_in);
    assign carries[3] = g2
                      | (p2 & g1)
                      | (p2 & p1 & g0)
                      | (p2 & p1 & p0 & c_in);
    assign carries[4] = g3
                      | (p3 & g2)
                      | (p3 & p2 & g1)
                      | (p3 & p2 & p1 & g0)
                      | (p3 & p2 & p1 & p0 & c_in);

    for (genvar i = 0; i < GRP_W; i++) begin : g_chk
        always_comb begin
            if (pg_in[i].gen)
                AST_GEN_SETS_CARRY: assert (carries[i+1]);                     // R1
            if (!pg_in[i].prop)
                AST_ZERO_PAIR_KILLS: assert (!carries[i+1]);                   // R2
            if (pg_in[i].prop && !pg_in[i].gen)
                AST_SINGLE_ONE_PASSES: assert (carries[i+1] == carries[i]);    // R2
        end
    end

endmodule

// File: rtl/cla_sum_unit.sv
module cla_sum_unit
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] a_in,
    input  logic [GRP_W-1:0] b_in,
    input  logic [GRP_W-1:0] c_vec,
    output logic [GRP_W-1:0] s_out
);

    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
        assign s_out[i] = a_in[i] ^ b_in[i] ^ c_vec[i];
    end

endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] a_in,
    input  logic [GRP_W-1:0] b_in,
    input  logic             c_in,
    output logic [GRP_W-1:0] s_out,
    output logic             c_out
);

    pg_t  [GRP_W-1:0] pg;
    logic [GRP_W:0]   carries;

    cla_pg_unit i_pg (
        .a_in   (a_in),
        .b_in   (b_in),
        .pg_out (pg)
    );

    cla_carry_unit i_carry (
        .pg_in   (pg),
        .c_in    (c_in),
        .carries (carries)
    );

    cla_sum_unit i_sum (
        .a_in  (a_in),
        .b_in  (b_in),
        .c_vec (carries[GRP_W-1:0]),
        .s_out (s_out)
    );

    assign c_out = carries[GRP_W];

    always_comb begin
        AST_SLICE_RESULT: assert ({c_out, s_out} ==
            ({1'b0, a_in} + {1'b0, b_in} + {{GRP_W{1'b0}}, c_in}));            // R4
    end

endmodule

// File: rtl/cla_hybrid_adder.sv
module cla_hybrid_adder
    import cla_pkg::*;
#(
    parameter int unsigned NUM_GRP = 4,
    localparam int unsigned WIDTH  = NUM_GRP * GRP_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    logic grp_c [NUM_GRP+1];

    assign grp_c[0] = carry_in;

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        cla_group i_group (
            .a_in  (op_a[k*GRP_W +: GRP_W]),
            .b_in  (op_b[k*GRP_W +: GRP_W]),
            .c_in  (grp_c[k]),
            .s_out (sum_out[k*GRP_W +: GRP_W]),
            .c_out (grp_c[k+1])
        );
    end

    assign carry_out = grp_c[NUM_GRP];

    always_comb begin
        AST_FULL_SUM: assert ({carry_out, sum_out} ==
            ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));       // R8
    end

endmodule

// File: tb/test_cla_hybrid_adder.sv
`timescale 1ns/1ps
module test_cla_hybrid_adder;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          carry_in = 1'b0;
    logic [W-1:0]  sum_out;
    logic          carry_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cla_hybrid_adder #(.NUM_GRP(4)) i_cla_hybrid_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // Bit-serial reference: carry into each position, index W is the carry out.
    function automatic logic [W:0] ref_carries(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic ci);
        logic [W:0] c;
        c[0] = ci;
        for (int i = 0; i < W; i++)
            c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
        return c;
    endfunction

    task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic ci, input string tag);
        logic [W:0] exp_res;
        logic [W:0] exp_c;
        logic [W:0] got_c;
        @(posedge clk);
        op_a = a;
        op_b = b;
        carry_in = ci;
        @(negedge clk);
        exp_res = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        n_tests++;
        if ({carry_out, sum_out} !== exp_res) begin
            n_fail++;
            $display("FAIL %s (R8 result) a=%h b=%h cin=%0d got %h expected %h",
                     tag, a, b, ci, {carry_out, sum_out}, exp_res);
        end
        // R3/R4: carries recovered from sum bits must match bit-serial ones
        exp_c = ref_carries(a, b, ci);
        got_c = {carry_out, a ^ b ^ sum_out};
        n_tests++;
        if (got_c !== exp_c) begin
            n_fail++;
            $display("FAIL %s (R3/R4 carries) a=%h b=%h cin=%0d got %h expected %h",
                     tag, a, b, ci, got_c, exp_c);
        end
    endtask

    initial begin
        int unsigned seed_val;
        logic [W-1:0] ra, rb;
        seed_val = $urandom(32'h0C1A_5EED);

        run_vec(16'h0000, 16'h0000, 1'b0, "R7 all zero");
        run_vec(16'h0000, 16'h0000, 1'b1, "R7 zero plus cin");
        run_vec(16'hFFFF, 16'h0001, 1'b0, "R6 all ones plus one");
        run_vec(16'hFFFF, 16'h0000, 1'b1, "R9 cin through all slices");
        run_vec(16'hFFFF, 16'hFFFF, 1'b1, "R8 max operands");
        run_vec(16'h000F, 16'h0001, 1'b0, "R5 slice crossing");
        run_vec(16'h00F0, 16'h0010, 1'b0, "R5 second boundary");
        run_vec(16'h0FFF, 16'h0001, 1'b0, "R5 third boundary");

        for (int i = 0; i < W; i++) begin
            logic [W-1:0] bitv;
            logic [W-1:0] low;
            bitv = 16'h1 << i;
            low  = bitv - 16'h1;
            // R1: generating pair at position i
            run_vec(bitv, bitv, 1'b0, "R1 generate");
            run_vec(bitv | 16'h5555 & low, bitv | 16'h2222 & low, 1'b0, "R1 generate over noise");
            // R2: propagate run from carry_in through bits 0..i
            run_vec(bitv | low, 16'h0000, 1'b1, "R2 propagate run");
            run_vec(16'h0000, bitv | low, 1'b1, "R2 propagate run on b");
            // R2: run up to i-1, zero pair at i stops it
            run_vec(low, 16'h0000, 1'b1, "R2 zero pair kills");
        end

        for (int n = 0; n < 3000; n++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            run_vec(ra, rb, 1'($urandom), "R8 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule